// File: doc/BRIEF.md
# ATA Task-File Register Controller

This block is the device side of a disk command interface. A host sees eight byte-wide register slots. It loads a sector count, a 28-bit block address and a device/mode byte, then writes a command code. The block runs three commands. IDENTIFY returns 256 description words through the data slot, using a data-request handshake. READ DMA and WRITE DMA move whole sectors through a word-wide port that a DMA engine drives. A small on-chip sector store holds the data that those transfers read and write.

Finished commands, and aborted ones, raise an interrupt line. Reading the status slot removes a pending interrupt. Only device 0 is modelled, and only block addressing is accepted for data commands. Register reads are combinational on `hst_rdata` while `hst_cs` is high. Any side effect of an access, such as taking the next IDENTIFY word or clearing the interrupt, happens at the rising clock edge where that access is sampled.

Top module: `ata_taskfile_ctrl`

## Requirements
- R1: After reset the status slot (offset 7) reads 0x40, the error slot (offset 1) reads 0x00, and `irq` and `dma_req` are low. Status bits are BSY 0x80, DRDY 0x40, DF 0x20, DRQ 0x08 and ERR 0x01.
- R2: Writes to offset 2 (sector count), 3, 4 and 5 (address bytes 0, 1 and 2) and 6 (device/mode) are stored from `hst_wdata[7:0]`. Reading those offsets returns the stored byte, with `hst_rdata[15:8]` equal to 0.
- R3: Command 0xEC (IDENTIFY) is accepted while idle. From the next cycle the status reads 0x48 and `irq` is 1. Each read of offset 0 takes the next word. After exactly 256 such reads the status reads 0x40.
- R4: The IDENTIFY words are as follows. Word 0 is 0x0040. Word 49 has bit 9 set. Words 10 to 19 hold the 20-character text "UNIT-SERIAL-00000001", with the first character in the high byte. Words 23 to 26 hold the 8 characters "FW-1.02 ". Words 60 and 61 give the low and high halves of the sector capacity (4 by default). Word 85 is 0x0020, which reports the write cache as enabled. All other words are 0.
- R5: A read of offset 7 clears `irq` at that edge, unless a new event raises it in the same cycle. A read of offset 1 leaves `irq` unchanged.
- R6: Command 0xC8 (READ DMA) with device bit 6 set makes `dma_req`=1 and `dma_dir`=1, and the status reads 0xC0. On each cycle with `dma_ack`=1 it presents one word on `dma_rdata`. Words come in order from sector (address mod 4), word 0 upward.
- R7: Command 0xCA (WRITE DMA) with device bit 6 set makes `dma_req`=1 and `dma_dir`=0. On each cycle with `dma_ack`=1 it stores `dma_wdata` into the next word of the same address sequence.
- R8: The edge that takes the last word of the last sector drops `dma_req`, sets `irq` and returns the status to 0x40.
- R9: A sector count of n moves n×256 words, with a count of 0 meaning 256 sectors. Sectors follow one another and wrap around the 4-sector store.
- R10: A DMA command with device bit 6 clear is aborted. The status becomes 0x41, the error slot reads 0x04, `irq` is set and `dma_req` stays low.
- R11: An unknown command code is aborted in the same way: the status reads 0x41, the error slot reads 0x04 and `irq` is set. The next accepted command clears ERR and the error slot.
- R12: A command written while device bit 4 is set is ignored. The status and `irq` are unchanged and no transfer starts.
- R13: A command written while BSY or DRQ is set is ignored, and the running transfer continues unchanged.
- R14: A read of offset 0 while DRQ is clear returns 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_cs | input | 1 | Host access strobe, sampled each rising edge |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 3 | Register slot offset |
| hst_wdata | input | 16 | Host write data (byte slots use bits 7:0) |
| hst_rdata | output | 16 | Combinational read data for the addressed slot |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | Sector transfer in progress |
| dma_dir | output | 1 | 1 = device to memory, 0 = memory to device |
| dma_ack | input | 1 | One word moves at this edge |
| dma_wdata | input | 16 | Word from memory for WRITE DMA |
| dma_rdata | output | 16 | Word to memory for READ DMA |

## Verification
Each command write takes effect at the edge that samples it. The bench therefore reads the new status, `irq` or `dma_req` in the cycle that follows, which is the very next falling edge.

Read data is combinational, so every slot value is sampled shortly after the falling edge of the access cycle. Its side effect, such as the next IDENTIFY word or a cleared interrupt, is checked one cycle later. DMA words are compared at the falling edge before the edge that consumes them. The drop of `dma_req` is observed at the first falling edge after the final acknowledged word, and the word count is checked against n×256 at that point.

// File: rtl/ata_tf_pkg.sv
// Package: shared slot offsets, status/error encodings, command codes and
// the transfer phase type of the task-file controller.
package ata_tf_pkg;
    localparam logic [2:0] OFS_DATA  = 3'd0;
    localparam logic [2:0] OFS_ERR   = 3'd1;
    localparam logic [2:0] OFS_COUNT = 3'd2;
    localparam logic [2:0] OFS_LBA0  = 3'd3;
    localparam logic [2:0] OFS_LBA1  = 3'd4;
    localparam logic [2:0] OFS_LBA2  = 3'd5;
    localparam logic [2:0] OFS_DEV   = 3'd6;
    localparam logic [2:0] OFS_STAT  = 3'd7;

    localparam int ST_BSY  = 7;
    localparam int ST_DRDY = 6;
    localparam int ST_DF   = 5;
    localparam int ST_DRQ  = 3;
    localparam int ST_ERR  = 0;

    localparam int DEV_LBA_BIT = 6;
    localparam int DEV_SEL_BIT = 4;

    localparam logic [7:0] ERR_ABRT = 8'h04;

    localparam logic [7:0] CMD_RD_DMA = 8'hC8;
    localparam logic [7:0] CMD_WR_DMA = 8'hCA;
    localparam logic [7:0] CMD_IDENT  = 8'hEC;

    localparam int ID_WORDS = 256;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_PIO_IN  = 2'd1,
        PH_DMA_IN  = 2'd2,
        PH_DMA_OUT = 2'd3
    } phase_t;
endpackage

// File: rtl/ata_tf_regs.sv
// Byte register bank: holds sector count, three address bytes and the
// device/mode byte, and forwards command writes as a one-cycle strobe.
// Assumes the host presents each access for one sampled edge.
module ata_tf_regs
    import ata_tf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  addr,
    input  logic [7:0]  wdata,
    output logic        cmd_go,
    output logic [7:0]  cmd_code,
    output logic [7:0]  sec_count,
    output logic [27:0] lba28,
    output logic [7:0]  dev_reg,
    output logic [7:0]  rd_byte
);
    logic [7:0] lba0_q, lba1_q, lba2_q;

    // Capture byte writes into the addressed slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_count <= 8'h00;
            lba0_q    <= 8'h00;
            lba1_q    <= 8'h00;
            lba2_q    <= 8'h00;
            dev_reg   <= 8'h00;
        end else if (wr_en) begin
            case (addr)
                OFS_COUNT: sec_count <= wdata;
                OFS_LBA0:  lba0_q    <= wdata;
                OFS_LBA1:  lba1_q    <= wdata;
                OFS_LBA2:  lba2_q    <= wdata;
                OFS_DEV:   dev_reg   <= wdata;
                default:   ;
            endcase
        end
    end

    assign cmd_go   = wr_en && (addr == OFS_STAT);
    assign cmd_code = wdata;
    assign lba28    = {dev_reg[3:0], lba2_q, lba1_q, lba0_q};

    // Readback of the stored byte slots.
    always_comb begin
        case (addr)
            OFS_COUNT: rd_byte = sec_count;
            OFS_LBA0:  rd_byte = lba0_q;
            OFS_LBA1:  rd_byte = lba1_q;
            OFS_LBA2:  rd_byte = lba2_q;
            OFS_DEV:   rd_byte = dev_reg;
            default:   rd_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/ata_tf_fsm.sv
// Command sequencer: accepts commands while idle for device 0, runs the
// IDENTIFY data-in handshake and the sector DMA phases, and owns status,
// error and interrupt state. Assumes WPS and NUM_SECTORS are powers of two
// (at least 2) so word and sector counters wrap naturally.
module ata_tf_fsm
    import ata_tf_pkg::*;
#(
    parameter int WPS         = 256,
    parameter int NUM_SECTORS = 4,
    localparam int WW = $clog2(WPS),
    localparam int SW = $clog2(NUM_SECTORS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_go,
    input  logic [7:0]    cmd_code,
    input  logic [7:0]    dev_reg,
    input  logic [27:0]   lba28,
    input  logic [7:0]    sec_count,
    input  logic          rd_status,
    input  logic          rd_data,
    input  logic          dma_ack,
    output phase_t        phase,
    output logic [7:0]    status,
    output logic [7:0]    err_reg,
    output logic          irq,
    output logic [7:0]    id_idx,
    output logic [SW-1:0] cur_sec,
    output logic [WW-1:0] word_idx
);
    localparam logic [WW-1:0] LAST_WORD = WW'(WPS - 1);

    phase_t     phase_q;
    logic [8:0] left_q;
    logic       err_q;
    logic       irq_q;
    logic       accept, start_pio, start_dma, abort_cmd, in_dma, dma_done;
    logic       unused_lba;

    assign unused_lba = ^lba28[27:SW];

    // Decode of the command write into start/abort events.
    always_comb begin
        accept    = cmd_go && (phase_q == PH_IDLE) && !dev_reg[DEV_SEL_BIT];
        start_pio = accept && (cmd_code == CMD_IDENT);
        start_dma = accept && dev_reg[DEV_LBA_BIT] &&
                    ((cmd_code == CMD_RD_DMA) || (cmd_code == CMD_WR_DMA));
        abort_cmd = accept && !start_pio && !start_dma;
        in_dma    = (phase_q == PH_DMA_IN) || (phase_q == PH_DMA_OUT);
        dma_done  = in_dma && dma_ack && (word_idx == LAST_WORD) && (left_q == 9'd1);
    end

    // Phase and transfer counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            id_idx   <= 8'd0;
            cur_sec  <= '0;
            word_idx <= '0;
            left_q   <= 9'd0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start_pio) begin
                        phase_q <= PH_PIO_IN;
                        id_idx  <= 8'd0;
                    end else if (start_dma) begin
                        phase_q  <= (cmd_code == CMD_RD_DMA) ? PH_DMA_IN : PH_DMA_OUT;
                        cur_sec  <= lba28[SW-1:0];
                        word_idx <= '0;
                        left_q   <= (sec_count == 8'd0) ? 9'd256 : {1'b0, sec_count};
                    end
                end
                PH_PIO_IN: begin
                    if (rd_data) begin
                        id_idx <= id_idx + 8'd1;
                        if (id_idx == 8'(ID_WORDS - 1)) phase_q <= PH_IDLE;
                    end
                end
                default: begin
                    if (dma_ack) begin
                        word_idx <= word_idx + 1'b1;
                        if (word_idx == LAST_WORD) begin
                            cur_sec <= cur_sec + 1'b1;
                            left_q  <= left_q - 9'd1;
                            if (left_q == 9'd1) phase_q <= PH_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    // Error flag: set by an abort, cleared by the next accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n)                      err_q <= 1'b0;
        else if (abort_cmd)              err_q <= 1'b1;
        else if (start_pio || start_dma) err_q <= 1'b0;
    end

    // Interrupt: raising events win over a status-read clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 irq_q <= 1'b0;
        else if (start_pio || abort_cmd || dma_done) irq_q <= 1'b1;
        else if (rd_status)                         irq_q <= 1'b0;
    end

    assign phase   = phase_q;
    assign irq     = irq_q;
    assign err_reg = err_q ? ERR_ABRT : 8'h00;

    // Status byte assembled from phase and error state.
    always_comb begin
        status           = 8'h00;
        status[ST_BSY]   = in_dma;
        status[ST_DRDY]  = 1'b1;
        status[ST_DF]    = 1'b0;
        status[ST_DRQ]   = (phase_q == PH_PIO_IN);
        status[ST_ERR]   = err_q;
    end
endmodule

// File: rtl/ata_tf_ident.sv
// IDENTIFY word generator: computes each of the 256 description words from
// its index, with serial and firmware text taken from parameters.
module ata_tf_ident #(
    parameter logic [159:0] SERIAL_TXT = "UNIT-SERIAL-00000001",
    parameter logic [63:0]  FW_TXT     = "FW-1.02 ",
    parameter int           NUM_SECTORS = 4
) (
    input  logic [7:0]  idx,
    output logic [15:0] word
);
    localparam logic [31:0] CAPACITY = 32'(NUM_SECTORS);

    // Word lookup by index.
    always_comb begin
        word = 16'h0000;
        if (idx >= 8'd10 && idx <= 8'd19) begin
            word = SERIAL_TXT[159 - 16 * (int'(idx) - 10) -: 16];
        end else if (idx >= 8'd23 && idx <= 8'd26) begin
            word = FW_TXT[63 - 16 * (int'(idx) - 23) -: 16];
        end else begin
            case (idx)
                8'd0:    word = 16'h0040;
                8'd49:   word = 16'h0200;
                8'd60:   word = CAPACITY[15:0];
                8'd61:   word = CAPACITY[31:16];
                8'd85:   word = 16'h0020;
                default: word = 16'h0000;
            endcase
        end
    end
endmodule

// File: rtl/ata_tf_store.sv
// Sector storage model: word array with synchronous write and
// combinational read, addressed by {sector, word}.
module ata_tf_store #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Store one word per write enable.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/ata_taskfile_ctrl.sv
// Task-file controller top: decodes host slot accesses, ties the register
// bank, sequencer, IDENTIFY generator and sector store together, and drives
// the DMA word port. Reads are combinational; side effects occur at the
// sampling edge.
module ata_taskfile_ctrl
    import ata_tf_pkg::*;
#(
    parameter int           WORDS_PER_SECTOR = 256,
    parameter int           NUM_SECTORS      = 4,
    parameter logic [159:0] SERIAL_TXT       = "UNIT-SERIAL-00000001",
    parameter logic [63:0]  FW_TXT           = "FW-1.02 "
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hst_cs,
    input  logic        hst_wr,
    input  logic [2:0]  hst_addr,
    input  logic [15:0] hst_wdata,
    output logic [15:0] hst_rdata,
    output logic        irq,
    output logic        dma_req,
    output logic        dma_dir,
    input  logic        dma_ack,
    input  logic [15:0] dma_wdata,
    output logic [15:0] dma_rdata
);
    localparam int WW = $clog2(WORDS_PER_SECTOR);
    localparam int SW = $clog2(NUM_SECTORS);

    logic          cmd_go;
    logic [7:0]    cmd_code, sec_count, dev_w, rd_byte, stat_w, err_w, id_idx;
    logic [27:0]   lba28;
    logic          rd_status, rd_data;
    phase_t        phase;
    logic [SW-1:0] cur_sec;
    logic [WW-1:0] word_idx;
    logic [15:0]   id_word;
    logic          unused_hi;

    assign unused_hi = ^hst_wdata[15:8];
    assign rd_status = hst_cs && !hst_wr && (hst_addr == OFS_STAT);
    assign rd_data   = hst_cs && !hst_wr && (hst_addr == OFS_DATA);

    ata_tf_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (hst_cs && hst_wr),
        .addr      (hst_addr),
        .wdata     (hst_wdata[7:0]),
        .cmd_go    (cmd_go),
        .cmd_code  (cmd_code),
        .sec_count (sec_count),
        .lba28     (lba28),
        .dev_reg   (dev_w),
        .rd_byte   (rd_byte)
    );

    ata_tf_fsm #(
        .WPS         (WORDS_PER_SECTOR),
        .NUM_SECTORS (NUM_SECTORS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_go    (cmd_go),
        .cmd_code  (cmd_code),
        .dev_reg   (dev_w),
        .lba28     (lba28),
        .sec_count (sec_count),
        .rd_status (rd_status),
        .rd_data   (rd_data),
        .dma_ack   (dma_ack),
        .phase     (phase),
        .status    (stat_w),
        .err_reg   (err_w),
        .irq       (irq),
        .id_idx    (id_idx),
        .cur_sec   (cur_sec),
        .word_idx  (word_idx)
    );

    ata_tf_ident #(
        .SERIAL_TXT  (SERIAL_TXT),
        .FW_TXT      (FW_TXT),
        .NUM_SECTORS (NUM_SECTORS)
    ) u_ident (
        .idx  (id_idx),
        .word (id_word)
    );

    ata_tf_store #(
        .WORD_W (16),
        .ADDR_W (SW + WW)
    ) u_store (
        .clk   (clk),
        .we    ((phase == PH_DMA_OUT) && dma_ack),
        .addr  ({cur_sec, word_idx}),
        .wdata (dma_wdata),
        .rdata (dma_rdata)
    );

    assign dma_req = (phase == PH_DMA_IN) || (phase == PH_DMA_OUT);
    assign dma_dir = (phase == PH_DMA_IN);

    // Host read multiplexer.
    always_comb begin
        case (hst_addr)
            OFS_DATA: hst_rdata = stat_w[ST_DRQ] ? id_word : 16'h0000;
            OFS_ERR:  hst_rdata = {8'h00, err_w};
            OFS_STAT: hst_rdata = {8'h00, stat_w};
            default:  hst_rdata = {8'h00, rd_byte};
        endcase
    end
endmodule

// File: rtl/ata_taskfile_chk.sv
// Checker: temporal properties of the task-file controller, bound to the top.
module ata_taskfile_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hst_cs,
    input logic       hst_wr,
    input logic [2:0] hst_addr,
    input logic       irq,
    input logic       dma_req,
    input logic [7:0] status,
    input logic [7:0] dev_reg
);
    logic       rd_stat, rd_dat, cmd_wr;
    logic [9:0] pio_cnt;

    assign rd_stat = hst_cs && !hst_wr && (hst_addr == 3'd7);
    assign rd_dat  = hst_cs && !hst_wr && (hst_addr == 3'd0);
    assign cmd_wr  = hst_cs && hst_wr && (hst_addr == 3'd7);

    // Count data-slot reads during a data-request phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !status[3]) pio_cnt <= 10'd0;
        else if (rd_dat)          pio_cnt <= pio_cnt + 10'd1;
    end

    AST_STATUS_READ_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !status[7] && !status[3]) |=> !irq); // R5
    AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_req) |-> (irq && !status[7])); // R8
    AST_PIO_WORD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[3]) |-> (pio_cnt == 10'd256)); // R3
    AST_CMD_WHILE_DRQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && status[3]) |=> (status[3] && !dma_req)); // R13
    AST_DEV1_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && dev_reg[4] && !status[7] && !status[3]) |=> ($stable(irq) && !dma_req && !status[3])); // R12
    AST_DMA_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (status[7] && !status[3])); // R6
endmodule

bind ata_taskfile_ctrl ata_taskfile_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hst_cs   (hst_cs),
    .hst_wr   (hst_wr),
    .hst_addr (hst_addr),
    .irq      (irq),
    .dma_req  (dma_req),
    .status   (stat_w),
    .dev_reg  (dev_w)
);

// File: tb/ata_taskfile_ctrl_tb.sv
// Directed bench for the task-file controller: one task per scenario.
module ata_taskfile_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_cs = 1'b0, hst_wr = 1'b0;
    logic [2:0]  hst_addr = 3'd0;
    logic [15:0] hst_wdata = 16'h0;
    logic [15:0] hst_rdata;
    logic        irq, dma_req, dma_dir;
    logic        dma_ack = 1'b0;
    logic [15:0] dma_wdata = 16'h0;
    logic [15:0] dma_rdata;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [15:0] idw [256];

    localparam logic [159:0] SN_TXT = "UNIT-SERIAL-00000001";
    localparam logic [63:0]  FW_TX  = "FW-1.02 ";

    always #(CLK_PERIOD/2) clk = ~clk;

    ata_taskfile_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .hst_cs(hst_cs), .hst_wr(hst_wr),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .irq(irq), .dma_req(dma_req), .dma_dir(dma_dir), .dma_ack(dma_ack),
        .dma_wdata(dma_wdata), .dma_rdata(dma_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        hst_cs = 1; hst_wr = 1; hst_addr = a; hst_wdata = {8'h00, v};
        @(posedge clk); #1;
        hst_cs = 0; hst_wr = 0;
    endtask

    task automatic host_rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        hst_cs = 1; hst_wr = 0; hst_addr = a;
        #1 d = hst_rdata;
        @(posedge clk); #1;
        hst_cs = 0;
    endtask

    function automatic logic [15:0] exp_id(input int i);
        if (i >= 10 && i <= 19) return SN_TXT[159 - 16*(i-10) -: 16];
        if (i >= 23 && i <= 26) return FW_TX[63 - 16*(i-23) -: 16];
        case (i)
            0: return 16'h0040;
            49: return 16'h0200;
            60: return 16'h0004;
            85: return 16'h0020;
            default: return 16'h0000;
        endcase
    endfunction

    // Read words while DRQ is up; count status values other than 0x48.
    task automatic pio_drain(output int n, output int bad_st, output logic [15:0] last_st);
        logic [15:0] s, d;
        n = 0; bad_st = 0;
        for (int k = 0; k < 300; k++) begin
            host_rd(3'd7, s);
            if (!s[3]) break;
            if (s !== 16'h0048) bad_st++;
            host_rd(3'd0, d);
            if (n < 256) idw[n] = d;
            n++;
        end
        last_st = s;
    endtask

    // Acknowledge every cycle while dma_req is up; drive seed+n, compare on reads.
    task automatic dma_xfer(input bit is_rd, input logic [15:0] seed, input int limit,
                            output int n, output int bad);
        n = 0; bad = 0;
        @(negedge clk);
        dma_ack = 1;
        while (dma_req && n < limit) begin
            dma_wdata = seed + 16'(n);
            if (is_rd && dma_rdata !== seed + 16'(n)) bad++;
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        dma_ack = 0;
    endtask

    task automatic set_addr(input logic [7:0] cnt, input logic [7:0] l0, input logic [7:0] l1,
                            input logic [7:0] l2, input logic [7:0] dev);
        host_wr(3'd2, cnt); host_wr(3'd3, l0); host_wr(3'd4, l1);
        host_wr(3'd5, l2); host_wr(3'd6, dev);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        @(negedge clk);
        check("R1 irq", irq, 0);
        check("R1 dma_req", dma_req, 0);
        host_rd(3'd7, d); check("R1 status", d, 16'h0040);
        host_rd(3'd1, d); check("R1 error", d, 16'h0000);
    endtask

    task automatic t_regs();
        logic [15:0] d;
        logic [7:0] v [5] = '{8'hA5, 8'h5A, 8'h3C, 8'hC3, 8'h4E};
        for (int k = 0; k < 5; k++) host_wr(3'(k + 2), v[k]);
        for (int k = 0; k < 5; k++) begin
            host_rd(3'(k + 2), d);
            check("R2 readback", d, {8'h00, v[k]});
        end
    endtask

    task automatic t_identify();
        logic [15:0] d, st;
        int n, bs, bw;
        host_wr(3'd6, 8'h00);
        host_wr(3'd7, 8'hEC);
        @(negedge clk); check("R3 irq after IDENTIFY", irq, 1);
        host_rd(3'd1, d); check("R11 error clear on IDENTIFY", d, 0);
        @(negedge clk); check("R5 error read keeps irq", irq, 1);
        host_rd(3'd7, d); check("R3 status during transfer", d, 16'h0048);
        @(negedge clk); check("R5 status read clears irq", irq, 0);
        pio_drain(n, bs, st);
        check("R3 word count", n, 256);
        check("R3 status 0x48 on every poll", bs, 0);
        check("R3 final status", st, 16'h0040);
        bw = 0;
        for (int i = 0; i < 256; i++) if (idw[i] !== exp_id(i)) bw++;
        check("R4 identify mismatching words", bw, 0);
        check("R4 serial word 10", idw[10], 16'h554E);
        check("R4 firmware word 26", idw[26], 16'h3220);
        check("R4 word 85", idw[85], 16'h0020);
        host_rd(3'd0, d); check("R14 data read idle", d, 0);
        host_rd(3'd7, d); check("R14 status unchanged", d, 16'h0040);
    endtask

    task automatic t_dma();
        logic [15:0] d;
        int n, bad;
        // write 2 sectors starting at address 0x5123401 -> sector 1
        set_addr(8'd2, 8'h01, 8'h34, 8'h12, 8'h45);
        host_wr(3'd7, 8'hCA);
        @(negedge clk);
        check("R7 dma_req", dma_req, 1);
        check("R7 dma_dir", dma_dir, 0);
        host_rd(3'd7, d); check("R6 busy status", d, 16'h00C0);
        dma_xfer(0, 16'h1000, 600, n, bad);
        check("R9 write count 2 sectors", n, 512);
        check("R8 irq at completion", irq, 1);
        check("R8 dma_req dropped", dma_req, 0);
        host_rd(3'd7, d); check("R8 status after DMA", d, 16'h0040);
        // read sector 2 (second written sector)
        set_addr(8'd1, 8'h02, 8'h00, 8'h00, 8'h40);
        host_wr(3'd7, 8'hC8);
        @(negedge clk);
        check("R6 dma_dir", dma_dir, 1);
        dma_xfer(1, 16'h1100, 600, n, bad);
        check("R6 read count", n, 256);
        check("R7 read-back mismatches", bad, 0);
        // wrap: write sectors 3,0 then read sector 0
        set_addr(8'd2, 8'h03, 8'h00, 8'h00, 8'h40);
        host_wr(3'd7, 8'hCA);
        dma_xfer(0, 16'h3000, 600, n, bad);
        set_addr(8'd1, 8'h00, 8'h00, 8'h00, 8'h40);
        host_wr(3'd7, 8'hC8);
        dma_xfer(1, 16'h3100, 600, n, bad);
        check("R9 wrap read mismatches", bad, 0);
        host_rd(3'd7, d);
    endtask

    task automatic t_count_zero();
        int n, bad;
        logic [15:0] d;
        set_addr(8'd0, 8'h00, 8'h00, 8'h00, 8'h40);
        host_wr(3'd7, 8'hCA);
        dma_xfer(0, 16'h0000, 70000, n, bad);
        check("R9 count 0 means 256 sectors", n, 65536);
        set_addr(8'd1, 8'h00, 8'h00, 8'h00, 8'h40);
        host_wr(3'd7, 8'hC8);
        dma_xfer(1, 16'hFC00, 600, n, bad);
        check("R9 last pass contents", bad, 0);
        host_rd(3'd7, d);
    endtask

    task automatic t_aborts();
        logic [15:0] d, st;
        int n, bs;
        host_wr(3'd6, 8'h00);
        host_wr(3'd7, 8'hC8);
        @(negedge clk);
        check("R10 no dma_req", dma_req, 0);
        check("R10 irq", irq, 1);
        host_rd(3'd7, d); check("R10 status", d, 16'h0041);
        host_rd(3'd1, d); check("R10 error", d, 16'h0004);
        host_wr(3'd7, 8'h55);
        @(negedge clk); check("R11 irq", irq, 1);
        host_rd(3'd7, d); check("R11 status", d, 16'h0041);
        host_rd(3'd1, d); check("R11 error abort bit", d, 16'h0004);
        host_wr(3'd7, 8'hEC);
        host_rd(3'd1, d); check("R11 error cleared", d, 16'h0000);
        // R13: command during DRQ ignored
        host_wr(3'd7, 8'hC8);
        @(negedge clk); check("R13 no dma_req", dma_req, 0);
        pio_drain(n, bs, st);
        check("R13 full word count", n, 256);
        check("R13 final status", st, 16'h0040);
    endtask

    task automatic t_dev1();
        logic [15:0] d;
        host_rd(3'd7, d);
        host_wr(3'd6, 8'h50);
        host_wr(3'd7, 8'hEC);
        @(negedge clk);
        check("R12 irq unchanged", irq, 0);
        check("R12 no dma_req", dma_req, 0);
        host_rd(3'd7, d); check("R12 status unchanged", d, 16'h0040);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_regs();
        t_identify();
        t_dma();
        t_count_zero();
        t_aborts();
        t_dev1();
        summary();
    end
endmodule